// File: doc/BRIEF.md
# Banked Memory Address Mapper

This block sits between an 8-bit CPU bus and a cartridge's program and pattern memories. It watches CPU writes to the upper half of the address space. From those writes it keeps a small register file: a target index with two mode flags, eight 1 KiB pattern bank numbers, three switchable 8 KiB program bank numbers and a nametable mirroring flag. It then extends two incoming addresses. A CPU address in the upper 32 KiB becomes a physical program address. A 13-bit video pattern address becomes a physical pattern address.

Software first writes a select byte, which holds the register index and the two mode flags. It then writes a data byte, which is stored in one or two bank slots. Which slots are loaded depends on the index and on the mode flags in force at the moment of the data write. A later change of the mode flags does not move slots that are already loaded. The last 8 KiB program window is always wired to the highest bank. Translation is combinational from the stored slots and the incoming address bits.

Top module: `bank_mapper_top`

## Requirements
- R1: After synchronous reset, program slots 0 to 3 hold bank 0xFF, pattern slot n holds bank n (n = 0..7), mirroring reads 0 (vertical), and the index and both mode flags are 0.
- R2: A write is decoded only when address bits 15..12 are 8, A, C or E and address bits 1..0 are 00 (select) or 01 (data at 8, no other). Address bits 11..2 are ignored. Writes with bit 12 or bit 1 set, to A001, or to any C/E register change nothing.
- R3: A select write (0x8000) stores data bits 3..0 as the index, data bit 6 as the program swap flag and data bit 7 as the pattern invert flag.
- R4: A data write (0x8001) with index 0 loads a 2 KiB pair, with slots 0/1 when invert is 0 and slots 4/5 when invert is 1. Index 1 loads slots 2/3 or 6/7 in the same way. The even slot takes the data and the odd slot takes data+1 modulo 256.
- R5: Data writes with index 2, 3, 4 or 5 load one pattern slot: 4, 5, 6 or 7 when invert is 0, and 0, 1, 2 or 3 when invert is 1.
- R6: A data write with index 8 loads pattern slot 1, and one with index 9 loads pattern slot 3, whatever the invert flag.
- R7: Data writes with index 6, 7 or 15 load program slots 0, 1 and 2 (windows 0x8000, 0xA000, 0xC000) when swap is 0, and slots 1, 2 and 0 when swap is 1.
- R8: Program slot 3 (window 0xE000) always yields bank 0xFF.
- R9: A write to 0xA000 sets the mirroring output to data bit 0, where 1 means horizontal; the setting appears the cycle after the write.
- R10: Data writes with index 10 to 14 change no slot.
- R11: Changing the mode flags leaves loaded slots in place, and the last data write to a slot takes effect.
- R12: prg_addr = {program slot[cpu_addr 14..13], cpu_addr 12..0} and chr_addr = {pattern slot[ppu_addr 12..10], ppu_addr 9..0}, combinationally; a data write is visible from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used for both decode and program translation |
| cpu_wdata | input | 8 | CPU write data |
| ppu_addr | input | 13 | Video pattern address |
| prg_addr | output | 21 | Physical program address (8-bit bank, 13-bit offset) |
| chr_addr | output | 18 | Physical pattern address (8-bit bank, 10-bit offset) |
| mirror_horiz | output | 1 | Nametable mirroring, 1 = horizontal, 0 = vertical |

## Verification
The select register and the bank file collide when a select write is followed at once by a data write. The data write must use the index and flags stored one edge earlier, not the older ones. Random streams of select, data and mirroring writes make these back-to-back pairs often, and directed sequences change the flags between loads. After every write, every pattern slot and program window is probed, as well as the mirroring output, and each is compared with a bench model that applies the requirements in write order.

// File: rtl/bank_mapper_pkg.sv
// Shared types and slot-targeting rules for the banked memory mapper.
// Assumes an 8-bit write data bus and fixed slot counts (8 pattern, 4 program).
package bank_mapper_pkg;

    localparam int CHR_SLOTS   = 8;
    localparam int PRG_SLOTS   = 4;
    localparam int CHR_SLOT_W  = $clog2(CHR_SLOTS);
    localparam int PRG_SLOT_W  = $clog2(PRG_SLOTS);
    localparam int DATA_W      = 8;

    localparam logic [3:0] IDX_PAIR_A  = 4'd0;
    localparam logic [3:0] IDX_PAIR_B  = 4'd1;
    localparam logic [3:0] IDX_ONE_0   = 4'd2;
    localparam logic [3:0] IDX_ONE_1   = 4'd3;
    localparam logic [3:0] IDX_ONE_2   = 4'd4;
    localparam logic [3:0] IDX_ONE_3   = 4'd5;
    localparam logic [3:0] IDX_PRG_0   = 4'd6;
    localparam logic [3:0] IDX_PRG_1   = 4'd7;
    localparam logic [3:0] IDX_ALT_S1  = 4'd8;
    localparam logic [3:0] IDX_ALT_S3  = 4'd9;
    localparam logic [3:0] IDX_PRG_2   = 4'd15;

    // Kind of bus write after address decode
    typedef enum logic [1:0] {
        WK_NONE   = 2'd0,
        WK_SELECT = 2'd1,
        WK_DATA   = 2'd2,
        WK_MIRROR = 2'd3
    } wr_kind_t;

    // Stored select byte: target index and the two placement flags
    typedef struct packed {
        logic [3:0] idx;
        logic       prg_swap;
        logic       chr_inv;
    } sel_t;

    // Pattern slot targeting: returns {hit, use_data_plus_one}
    function automatic logic [1:0] chr_target(input logic [3:0] idx,
                                              input logic       inv,
                                              input logic [2:0] slot);
        logic hit;
        logic inc;
        hit = 1'b0;
        inc = 1'b0;
        case (idx)
            IDX_PAIR_A, IDX_PAIR_B: begin
                hit = (slot[2] == inv) && (slot[1] == idx[0]);
                inc = slot[0];
            end
            IDX_ONE_0, IDX_ONE_1, IDX_ONE_2, IDX_ONE_3: begin
                hit = (slot == {~inv, 2'(idx - 4'd2)});
            end
            IDX_ALT_S1: hit = (slot == 3'd1);
            IDX_ALT_S3: hit = (slot == 3'd3);
            default:    hit = 1'b0;
        endcase
        return {hit, inc};
    endfunction

    // Program slot targeting: returns 1 when the slot is loaded
    function automatic logic prg_target(input logic [3:0] idx,
                                        input logic       swap,
                                        input logic [1:0] slot);
        logic hit;
        case (idx)
            IDX_PRG_0: hit = (slot == (swap ? 2'd1 : 2'd0));
            IDX_PRG_1: hit = (slot == (swap ? 2'd2 : 2'd1));
            IDX_PRG_2: hit = (slot == (swap ? 2'd0 : 2'd2));
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/bank_mapper_wr_decode.sv
// Decodes CPU writes and holds the select byte and the mirroring flag.
// Assumes cpu_wr is a single-cycle strobe; only bits 15..12 and 1..0 decode.
module bank_mapper_wr_decode
    import bank_mapper_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_wr,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output sel_t        sel,
    output logic        data_we,
    output logic        mirror_horiz
);

    wr_kind_t kind;
    sel_t     sel_q;
    logic     mirror_q;

    // Classify the current bus cycle
    always_comb begin
        kind = WK_NONE;
        if (cpu_wr && cpu_addr[15] && !cpu_addr[12] && !cpu_addr[1]) begin
            case ({cpu_addr[14:13], cpu_addr[0]})
                3'b000:  kind = WK_SELECT;
                3'b001:  kind = WK_DATA;
                3'b010:  kind = WK_MIRROR;
                default: kind = WK_NONE;
            endcase
        end
    end

    // Select byte register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (kind == WK_SELECT) begin
            sel_q.idx      <= cpu_wdata[3:0];
            sel_q.prg_swap <= cpu_wdata[6];
            sel_q.chr_inv  <= cpu_wdata[7];
        end
    end

    // Mirroring flag register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mirror_q <= 1'b0;
        end else if (kind == WK_MIRROR) begin
            mirror_q <= cpu_wdata[0];
        end
    end

    assign sel          = sel_q;
    assign data_we      = (kind == WK_DATA);
    assign mirror_horiz = mirror_q;

endmodule

// File: rtl/bank_mapper_chr_file.sv
// Eight 1 KiB pattern bank slots, loaded at data-write time, read by slot.
// Assumes sel holds the index and flags stored before this write.
module bank_mapper_chr_file
    import bank_mapper_pkg::*;
#(
    parameter int BANK_W = 8
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  data_we,
    input  sel_t                  sel,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [CHR_SLOT_W-1:0] rd_slot,
    output logic [BANK_W-1:0]     rd_bank
);

    logic [BANK_W-1:0] wval;
    logic [BANK_W-1:0] wval_inc;
    logic [CHR_SLOTS-1:0][BANK_W-1:0] slot_view;

    // Fit the write data to the bank width
    if (BANK_W == DATA_W) begin : g_fit_eq
        assign wval = wdata;
    end else if (BANK_W > DATA_W) begin : g_fit_ext
        assign wval = {{(BANK_W-DATA_W){1'b0}}, wdata};
    end else begin : g_fit_cut
        assign wval = wdata[BANK_W-1:0];
    end

    assign wval_inc = wval + BANK_W'(1);

    for (genvar s = 0; s < CHR_SLOTS; s++) begin : g_slot
        logic [1:0]        tgt;
        logic [BANK_W-1:0] bank_q;

        assign tgt = chr_target(sel.idx, sel.chr_inv, CHR_SLOT_W'(s));

        // Load this slot when the data write targets it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bank_q <= BANK_W'(s);
            end else if (data_we && tgt[1]) begin
                bank_q <= tgt[0] ? wval_inc : wval;
            end
        end

        assign slot_view[s] = bank_q;
    end

    assign rd_bank = slot_view[rd_slot];

endmodule

// File: rtl/bank_mapper_prg_file.sv
// Three switchable 8 KiB program slots plus one fixed to the last bank.
// Assumes the last bank number is all ones in BANK_W bits.
module bank_mapper_prg_file
    import bank_mapper_pkg::*;
#(
    parameter int BANK_W = 8
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  data_we,
    input  sel_t                  sel,
    input  logic [DATA_W-1:0]     wdata,
    input  logic [PRG_SLOT_W-1:0] rd_slot,
    output logic [BANK_W-1:0]     rd_bank
);

    localparam logic [BANK_W-1:0] LAST_BANK = '1;

    logic [BANK_W-1:0] wval;
    logic [PRG_SLOTS-1:0][BANK_W-1:0] slot_view;

    // Fit the write data to the bank width
    if (BANK_W == DATA_W) begin : g_fit_eq
        assign wval = wdata;
    end else if (BANK_W > DATA_W) begin : g_fit_ext
        assign wval = {{(BANK_W-DATA_W){1'b0}}, wdata};
    end else begin : g_fit_cut
        assign wval = wdata[BANK_W-1:0];
    end

    for (genvar s = 0; s < PRG_SLOTS; s++) begin : g_slot
        if (s == PRG_SLOTS - 1) begin : g_fixed
            assign slot_view[s] = LAST_BANK;
        end else begin : g_switch
            logic              hit;
            logic [BANK_W-1:0] bank_q;

            assign hit = prg_target(sel.idx, sel.prg_swap, PRG_SLOT_W'(s));

            // Load this slot when the data write targets it
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bank_q <= LAST_BANK;
                end else if (data_we && hit) begin
                    bank_q <= wval;
                end
            end

            assign slot_view[s] = bank_q;
        end
    end

    assign rd_bank = slot_view[rd_slot];

endmodule

// File: rtl/bank_mapper_top.sv
// Banked memory mapper: write decode, bank slot files and address extension.
// Assumes program translation is used only for cpu_addr in the upper 32 KiB.
module bank_mapper_top
    import bank_mapper_pkg::*;
#(
    parameter int PRG_BANK_W = 8,
    parameter int CHR_BANK_W = 8
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_wr,
    input  logic [15:0]            cpu_addr,
    input  logic [7:0]             cpu_wdata,
    input  logic [12:0]            ppu_addr,
    output logic [PRG_BANK_W+12:0] prg_addr,
    output logic [CHR_BANK_W+9:0]  chr_addr,
    output logic                   mirror_horiz
);

    localparam int PRG_OFF_W = 13;
    localparam int CHR_OFF_W = 10;

    sel_t                  sel;
    logic                  data_we;
    logic [PRG_BANK_W-1:0] prg_bank;
    logic [CHR_BANK_W-1:0] chr_bank;

    bank_mapper_wr_decode u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_wr       (cpu_wr),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .sel          (sel),
        .data_we      (data_we),
        .mirror_horiz (mirror_horiz)
    );

    bank_mapper_chr_file #(.BANK_W(CHR_BANK_W)) u_chr (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_we (data_we),
        .sel     (sel),
        .wdata   (cpu_wdata),
        .rd_slot (ppu_addr[12:CHR_OFF_W]),
        .rd_bank (chr_bank)
    );

    bank_mapper_prg_file #(.BANK_W(PRG_BANK_W)) u_prg (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_we (data_we),
        .sel     (sel),
        .wdata   (cpu_wdata),
        .rd_slot (cpu_addr[14:PRG_OFF_W]),
        .rd_bank (prg_bank)
    );

    // Extend the incoming offsets with the selected bank numbers
    assign prg_addr = {prg_bank, cpu_addr[PRG_OFF_W-1:0]};
    assign chr_addr = {chr_bank, ppu_addr[CHR_OFF_W-1:0]};

endmodule

// File: rtl/bank_mapper_checker.sv
// Port-level properties of the banked memory mapper, bound to the top.
// Assumes the same parameters as the top it is bound to.
module bank_mapper_checker #(
    parameter int PRG_BANK_W = 8,
    parameter int CHR_BANK_W = 8
)(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cpu_wr,
    input logic [15:0]            cpu_addr,
    input logic [7:0]             cpu_wdata,
    input logic [12:0]            ppu_addr,
    input logic [PRG_BANK_W+12:0] prg_addr,
    input logic [CHR_BANK_W+9:0]  chr_addr,
    input logic                   mirror_horiz
);

    logic mir_wr;
    assign mir_wr = cpu_wr && (cpu_addr[15:12] == 4'hA) && (cpu_addr[1:0] == 2'b00);

    // R1: the cycle after reset shows the default slots and vertical mirroring
    a_r1_reset_defaults: assert property (@(posedge clk)
        !rst_n |=> (!mirror_horiz
                    && (prg_addr[PRG_BANK_W+12:13] == {PRG_BANK_W{1'b1}})
                    && (chr_addr[CHR_BANK_W+9:10] == CHR_BANK_W'(ppu_addr[12:10]))));

    // R9: a mirroring write shows up one cycle later
    a_r9_mirror_follows: assert property (@(posedge clk) disable iff (!rst_n)
        mir_wr |=> (mirror_horiz == $past(cpu_wdata[0])));

    // R2: mirroring only changes on its own write
    a_r2_mirror_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mir_wr |=> $stable(mirror_horiz));

    // R8: the top program window always reads the last bank
    a_r8_top_window_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[14:13] == 2'b11) |-> (prg_addr[PRG_BANK_W+12:13] == {PRG_BANK_W{1'b1}}));

    // R12: offsets pass through translation unchanged
    a_r12_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((prg_addr[12:0] == cpu_addr[12:0]) && (chr_addr[9:0] == ppu_addr[9:0])));

endmodule

bind bank_mapper_top bank_mapper_checker #(
    .PRG_BANK_W (PRG_BANK_W),
    .CHR_BANK_W (CHR_BANK_W)
) u_chk (.*);

// File: tb/test_bank_mapper_top.sv
`timescale 1ns/1ps
// Bench for the banked memory mapper: directed cases plus seeded random writes.
module test_bank_mapper_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [12:0] ppu_addr = 13'h0000;
    logic [20:0] prg_addr;
    logic [17:0] chr_addr;
    logic        mirror_horiz;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Bench model of the register file
    logic [7:0] m_prg [4];
    logic [7:0] m_chr [8];
    logic       m_mir;
    logic [3:0] m_idx;
    logic       m_swp;
    logic       m_inv;

    always #2.5 clk = ~clk;

    bank_mapper_top i_bank_mapper_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_wr       (cpu_wr),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .ppu_addr     (ppu_addr),
        .prg_addr     (prg_addr),
        .chr_addr     (chr_addr),
        .mirror_horiz (mirror_horiz)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) m_prg[i] = 8'hFF;
        for (int i = 0; i < 8; i++) m_chr[i] = 8'(i);
        m_mir = 1'b0; m_idx = 4'd0; m_swp = 1'b0; m_inv = 1'b0;
    endtask

    // Apply one data byte to the model according to the stored index and flags
    task automatic model_data(input logic [7:0] d);
        int base;
        case (m_idx)
            4'd0, 4'd1: begin
                base = (m_inv ? 4 : 0) + (m_idx == 4'd1 ? 2 : 0);
                m_chr[base]     = d;
                m_chr[base + 1] = d + 8'd1;
            end
            4'd2, 4'd3, 4'd4, 4'd5: m_chr[(m_inv ? 0 : 4) + int'(m_idx) - 2] = d;
            4'd8:  m_chr[1] = d;
            4'd9:  m_chr[3] = d;
            4'd6:  m_prg[m_swp ? 1 : 0] = d;
            4'd7:  m_prg[m_swp ? 2 : 1] = d;
            4'd15: m_prg[m_swp ? 0 : 2] = d;
            default: ;
        endcase
    endtask

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a[15] && !a[12] && !a[1]) begin
            case ({a[14:13], a[0]})
                3'b000: begin m_idx = d[3:0]; m_swp = d[6]; m_inv = d[7]; end
                3'b001: model_data(d);
                3'b010: m_mir = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
        model_write(a, d);
    endtask

    // Probe every pattern slot, every program window and the mirroring flag
    task automatic check_all(input string req);
        for (int s = 0; s < 8; s++) begin
            logic [9:0] off;
            off = 10'($urandom);
            ppu_addr = {3'(s), off};
            #1;
            check(chr_addr == {m_chr[s], off}, req, int'(chr_addr), int'({m_chr[s], off}));
        end
        for (int s = 0; s < 4; s++) begin
            logic [12:0] off;
            off = 13'($urandom);
            cpu_addr = {1'b1, 2'(s), off};
            #1;
            check(prg_addr == {m_prg[s], off}, req, int'(prg_addr), int'({m_prg[s], off}));
        end
        check(mirror_horiz == m_mir, req, int'(mirror_horiz), int'(m_mir));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset defaults
        check_all("R1");

        // R3 and R4: pair loads with invert clear, then set, data+1 wraps
        bus_write(16'h8000, 8'h00);
        bus_write(16'h8001, 8'h20);
        bus_write(16'h8000, 8'h01);
        bus_write(16'h8001, 8'h40);
        check_all("R4");
        bus_write(16'h8000, 8'h80);
        bus_write(16'h8001, 8'hFF);
        bus_write(16'h8000, 8'h81);
        bus_write(16'h8001, 8'h10);
        check_all("R3");

        // R5: single slots in both invert settings
        for (int i = 2; i <= 5; i++) begin
            bus_write(16'h8000, 8'(i));
            bus_write(16'h8001, 8'(8'h50 + i));
            bus_write(16'h8000, 8'(8'h80 | i));
            bus_write(16'h8001, 8'(8'h60 + i));
        end
        check_all("R5");

        // R6: alternate single slots ignore invert
        bus_write(16'h8000, 8'h88);
        bus_write(16'h8001, 8'hA1);
        bus_write(16'h8000, 8'h09);
        bus_write(16'h8001, 8'hA3);
        check_all("R6");

        // R7: program placement with swap clear and set
        bus_write(16'h8000, 8'h06); bus_write(16'h8001, 8'h11);
        bus_write(16'h8000, 8'h07); bus_write(16'h8001, 8'h12);
        bus_write(16'h8000, 8'h0F); bus_write(16'h8001, 8'h13);
        check_all("R7");
        bus_write(16'h8000, 8'h46); bus_write(16'h8001, 8'h21);
        bus_write(16'h8000, 8'h47); bus_write(16'h8001, 8'h22);
        bus_write(16'h8000, 8'h4F); bus_write(16'h8001, 8'h23);
        check_all("R7");

        // R8: top window stays on the last bank after program loads
        cpu_addr = 16'hE123;
        #1;
        check(prg_addr[20:13] == 8'hFF, "R8", int'(prg_addr[20:13]), 8'hFF);

        // R11: flag change alone moves nothing; last write wins
        bus_write(16'h8000, 8'hC0);
        check_all("R11");
        bus_write(16'h8000, 8'h08);
        bus_write(16'h8001, 8'h77);
        check_all("R11");

        // R10: unused indices load nothing
        for (int i = 10; i <= 14; i++) begin
            bus_write(16'h8000, 8'(i));
            bus_write(16'h8001, 8'hEE);
        end
        check_all("R10");

        // R9: mirroring set, then cleared
        bus_write(16'hA000, 8'h01);
        check_all("R9");
        bus_write(16'hA000, 8'hFE);
        check_all("R9");

        // R2: ignored addresses and aliases of bits 11..2
        bus_write(16'hA001, 8'h01);
        bus_write(16'h9000, 8'h00);
        bus_write(16'h8000, 8'h02);
        bus_write(16'h9001, 8'h99);
        bus_write(16'h8003, 8'h99);
        bus_write(16'hC000, 8'h01);
        bus_write(16'hE001, 8'h01);
        bus_write(16'hAFFC, 8'h01);
        check_all("R2");
        bus_write(16'h8FFD, 8'h3C);
        check_all("R2");

        // R12: seeded random writes, back-to-back select and data pairs
        for (int n = 0; n < 400; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int          pick;
            pick = int'($urandom_range(0, 9));
            d    = 8'($urandom);
            case (pick)
                0, 1, 2: a = 16'h8000;
                3, 4, 5, 6: a = 16'h8001;
                7: a = 16'hA000;
                default: a = 16'($urandom);
            endcase
            if (pick <= 7) a[11:2] = 10'($urandom);
            if (pick <= 2 && d[3:0] >= 4'd10 && d[3:0] <= 4'd14) d[3:0] = 4'd15;
            bus_write(a, d);
            check_all("R12");
        end

        // R1: reset again after random traffic
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R1");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule